// File: doc/BRIEF.md
# Bi-Quinary Sound Timer Divider

This block turns the sound-processor clock into a slow timebase that software reads through an 8-bit input port. A clock-enable input marks each sound-processor clock. A 512-step binary prescaler counts these ticks, and each time it wraps it steps a decade sequencer. The sequencer counts in a bi-quinary order: a divide-by-2 stage feeds a divide-by-5 stage. The whole chain therefore divides by 5120.

The port's upper nibble carries a fixed bit pattern for each of the ten phases. The port's lower nibble is passed through unchanged from an external 4-bit input. The current phase index is also driven out so that it can be observed directly. Both outputs depend only on the current register state, so a read adds no latency.

Top module: `snd_timer_div`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `phase_o` is 0 and `port_o[7:4]` is 0x0.
- R2: On a cycle where `tick_en_i` is low, neither `phase_o` nor `port_o[7:4]` changes at the next clock edge.
- R3: `phase_o` steps by exactly one after every 512 enabled ticks counted from reset, and at no other time.
- R4: After phase 9, the next step returns `phase_o` to 0, so the port pattern repeats every 5120 enabled ticks.
- R5: `port_o[4]` is 1 exactly in the odd phases.
- R6: `port_o[5]` is 1 exactly in phases 2, 3, 6, 7 and 8.
- R7: `port_o[6]` is 1 exactly in phases 4 and 9.
- R8: `port_o[7]` is 1 exactly in phases 5 through 9. The resulting upper-nibble values for phases 0 to 9 are 0,1,2,3,4,9,A,B,A,D.
- R9: `port_o[3:0]` equals `lo_nibble_i` at all times, whatever the state of the timer.
- R10: `phase_o` never goes above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sound-processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Counts one tick when high |
| lo_nibble_i | input | 4 | Source for port bits 3:0 |
| port_o | output | 8 | Timer pattern in bits 7:4, pass-through in bits 3:0 |
| phase_o | output | 4 | Current decade phase, 0 to 9 |

## Verification
The assertions take for granted that `tick_en_i` and `lo_nibble_i` are defined at every clock edge outside reset. They also take for granted that reset is held for at least one edge, because the checker keeps its own tick counter, and that counter starts in step with the prescaler only from reset. The stimulus drives every input on the falling edge and leaves no input undefined. It applies an irregular enable pattern with periodic idle cycles across two full 5120-tick periods, and it changes the lower nibble on every cycle. It then resets the block in mid-count to confirm that the counters clear.

// File: rtl/snd_tmr_pkg.sv
package snd_tmr_pkg;
  localparam int unsigned PHASE_W = 4;
  localparam int unsigned NUM_PHASES = 10;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [3:0] nib_t;
endpackage

// File: rtl/snd_tmr_prescale.sv
module snd_tmr_prescale #(
  parameter int unsigned DIV = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wrap_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/snd_tmr_decade.sv
module snd_tmr_decade
  import snd_tmr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  output phase_t phase_o
);
  // divide-by-2 stage feeding a divide-by-5 stage
  logic       half_q;
  logic [2:0] quin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      quin_q <= '0;
    end else if (step_i) begin
      half_q <= ~half_q;
      if (half_q) quin_q <= (quin_q == 3'd4) ? 3'd0 : quin_q + 3'd1;
    end
  end

  assign phase_o = {quin_q, half_q};
endmodule

// File: rtl/snd_tmr_pattern.sv
module snd_tmr_pattern
  import snd_tmr_pkg::*;
(
  input  phase_t phase_i,
  output nib_t   hi_o
);
  always_comb begin
    unique case (phase_i)
      4'd0:    hi_o = 4'h0;
      4'd1:    hi_o = 4'h1;
      4'd2:    hi_o = 4'h2;
      4'd3:    hi_o = 4'h3;
      4'd4:    hi_o = 4'h4;
      4'd5:    hi_o = 4'h9;
      4'd6:    hi_o = 4'hA;
      4'd7:    hi_o = 4'hB;
      4'd8:    hi_o = 4'hA;
      4'd9:    hi_o = 4'hD;
      default: hi_o = 4'h0;
    endcase
  end
endmodule

// File: rtl/snd_timer_div.sv
module snd_timer_div
  import snd_tmr_pkg::*;
#(
  parameter int unsigned PRE_DIV = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_en_i,
  input  logic [3:0] lo_nibble_i,
  output logic [7:0] port_o,
  output logic [3:0] phase_o
);
  logic   step;
  phase_t phase;
  nib_t   hi;

  snd_tmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .wrap_o (step)
  );

  snd_tmr_decade u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .phase_o (phase)
  );

  snd_tmr_pattern u_pat (
    .phase_i (phase),
    .hi_o    (hi)
  );

  assign port_o  = {hi, lo_nibble_i};
  assign phase_o = phase;
endmodule

// File: rtl/snd_timer_div_chk.sv
module snd_timer_div_chk #(
  parameter int unsigned PRE_DIV = 512
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_en_i,
  input logic [3:0] lo_nibble_i,
  input logic [7:0] port_o,
  input logic [3:0] phase_o
);
  localparam int unsigned W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(PRE_DIV - 1);

  // independent tick counter for the step window
  logic [W-1:0] ref_cnt_q;
  logic         at_last;
  assign at_last = tick_en_i && (ref_cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ref_cnt_q <= '0;
    else if (at_last)   ref_cnt_q <= '0;
    else if (tick_en_i) ref_cnt_q <= ref_cnt_q + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (phase_o == 4'd0 && port_o[7:4] == 4'h0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !tick_en_i |=> ($stable(phase_o) && $stable(port_o[7:4]))); // R2
  AST_NO_EARLY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (tick_en_i && !at_last) |=> $stable(phase_o)); // R3
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (at_last && phase_o != 4'd9) |=> phase_o == $past(phase_o) + 4'd1); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (at_last && phase_o == 4'd9) |=> phase_o == 4'd0); // R4
  AST_BIT4_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni) port_o[4] == phase_o[0]); // R5
  AST_BIT7_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) port_o[7] == (phase_o >= 4'd5)); // R8
  AST_LO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni) port_o[3:0] == lo_nibble_i); // R9
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) phase_o <= 4'd9); // R10
endmodule

bind snd_timer_div snd_timer_div_chk #(.PRE_DIV(PRE_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_en_i   (tick_en_i),
  .lo_nibble_i (lo_nibble_i),
  .port_o      (port_o),
  .phase_o     (phase_o)
);

// File: tb/snd_timer_div_tb.sv
module snd_timer_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_en_i = 1'b0;
  logic [3:0] lo_nibble_i = 4'h0;
  logic [7:0] port_o;
  logic [3:0] phase_o;

  int total = 0;
  int bad = 0;
  int n = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  snd_timer_div u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_en_i   (tick_en_i),
    .lo_nibble_i (lo_nibble_i),
    .port_o      (port_o),
    .phase_o     (phase_o)
  );

  function automatic logic [3:0] exp_hi(input int p);
    logic [3:0] h;
    h[0] = (p % 2) == 1;                                   // R5
    h[1] = (p == 2 || p == 3 || p == 6 || p == 7 || p == 8); // R6
    h[2] = (p == 4 || p == 9);                             // R7
    h[3] = (p >= 5);                                       // R8
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    int p;
    logic [3:0] h;
    p = (n % 5120) / 512;
    h = exp_hi(p);
    chk(phase_o == 4'(p), {req, " phase"}, phase_o, p);
    chk(port_o[4] == h[0], "R5 bit4", port_o[4], h[0]);
    chk(port_o[5] == h[1], "R6 bit5", port_o[5], h[1]);
    chk(port_o[6] == h[2], "R7 bit6", port_o[6], h[2]);
    chk(port_o[7] == h[3], "R8 bit7", port_o[7], h[3]);
    chk(phase_o <= 4'd9, "R10 range", phase_o, 9);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(phase_o == 4'd0, "R1 phase in reset", phase_o, 0);
    chk(port_o[7:4] == 4'h0, "R1 nibble in reset", port_o[7:4], 0);
    tick_en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    n = 0;
    chk(phase_o == 4'd0 && port_o[7:4] == 4'h0, "R1 after reset", port_o[7:4], 0);

    // two full periods with irregular enables
    for (int i = 0; n < 2 * 5120 + 700; i++) begin
      logic [3:0] prev_hi;
      logic [3:0] prev_ph;
      tick_en_i = ((i % 7) != 3) && ((i % 13) != 5);
      lo_nibble_i = 4'(i * 5 + 3);
      #1;
      chk(port_o[3:0] == lo_nibble_i, "R9 lower nibble", port_o[3:0], lo_nibble_i);
      prev_hi = port_o[7:4];
      prev_ph = phase_o;
      @(negedge clk_i);
      if (tick_en_i) begin
        n++;
        if (n % 512 == 0) begin
          if ((n / 512) % 10 == 0)
            chk(phase_o == 4'd0, "R4 wrap to 0", phase_o, 0);
          else
            chk(phase_o == prev_ph + 4'd1, "R3 step", phase_o, prev_ph + 1);
        end else
          chk(phase_o == prev_ph, "R3 no step", phase_o, prev_ph);
      end else begin
        chk(phase_o == prev_ph && port_o[7:4] == prev_hi, "R2 idle hold", port_o[7:4], prev_hi);
      end
      check_state("R3");
    end

    // mid-count reset
    tick_en_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1;
    chk(phase_o == 4'd0 && port_o[7:4] == 4'h0, "R1 async clear", port_o[7:4], 0);
    @(negedge clk_i);
    tick_en_i = 1'b0;
    rst_ni = 1'b1;
    n = 0;
    @(negedge clk_i);
    check_state("R1");
    tick_en_i = 1'b1;
    repeat (512) begin
      @(negedge clk_i);
      n++;
    end
    tick_en_i = 1'b0;
    check_state("R3");
    chk(phase_o == 4'd1, "R3 first step after reset", phase_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule